// File: doc/BRIEF.md
# Processor Exception and Reset Controller

This controller decides when a small 32-bit pipelined processor abandons its normal instruction flow. Two active-high reset inputs, a main reset and a debug reset, restart fetch at address zero and put the architectural status registers into a known state. A set of fault strobes can raise a hardware exception. The strobes are bus faults on instruction fetch and on data access, an illegal major opcode in the decode stage, an unaligned data access, an integer divide by zero, and five floating-point fault classes. An exception redirects fetch to a fixed vector, squashes the pipeline, and saves what the handler needs to resume.

All outputs are registered. When an exception is taken, the cycle after the fault is sampled carries a one-cycle flush and redirect. In the same cycle the controller writes the decode-stage PC into link register 17 and shows the updated status, exception-status, exception-address, FP-status and branch-target registers. Optional causes exist only when the matching hardware unit is configured. A return-from-exception strobe re-opens the controller to new exceptions.

Top module: `exc_ctrl`

## Requirements
- R1: While `rst` or `dbg_rst` is high at a rising edge, the next cycle shows `flush`=1, `redir_vld`=1, `redir_pc`=0, `msr`=RESET_MSR, `link_we`=0, and `esr`, `ear`, `fsr` and `btr` all zero. This holds for either input alone.
- R2: A fault is taken when it is sampled with msr bit 8 (enable) at 1 and msr bit 9 (in progress) at 0. The next cycle then shows `flush`=1 and `redir_vld`=1 with `redir_pc`=0x20, and both strobes fall back to 0 one cycle later.
- R3: In the cycle that R2 describes, `link_we`=1, `link_idx`=17 and `link_data` equals the `dec_pc` that was sampled with the fault.
- R4: When a fault is taken with `dec_dslot`=1, esr bit 12 is 1 and `btr` takes `br_target`. When `dec_dslot`=0, esr bit 12 is 0 and `btr` keeps its value.
- R5: The illegal-opcode check looks only at the major opcode `instr[31:26]`, and only when `instr_vld`=1. Opcodes 0x30 to 0x3F are illegal. Opcode 0x12 (divide) is legal only when HAS_DIV=1, and opcode 0x16 (float) is legal only when HAS_FPU=1. Every other opcode from 0x00 to 0x2F is legal, and `instr[25:0]` never matters.
- R6: An instruction bus fault (`ibus_err` or `ibus_tmo`) counts only while `ibus_periph`=1. A data bus fault (`dbus_err` or `dbus_tmo`) counts only while `dbus_periph`=1. Otherwise these strobes are ignored.
- R7: When several faults arrive in the same cycle, esr[4:0] records one cause code. The order from first to last is: instruction bus (3), illegal opcode (2), data bus (4), unaligned (1), divide by zero (5), floating point (6).
- R8: For the instruction bus cause, `ear` takes `dec_pc`. For the data bus and unaligned causes, `ear` takes `data_addr`. The other causes leave `ear` unchanged.
- R9: `div_zero` raises an exception only when HAS_DIV=1. `fp_err` raises an exception only when HAS_FPU=1. When the unit is absent the strobe is ignored, which means no flush and `fsr` stays at 0.
- R10: A taken floating-point cause ORs `fp_err` into `fsr[4:0]`. The bits are sticky until reset.
- R11: Taking an exception sets msr bit 9 and clears msr bit 8. While msr bit 9 is 1 or msr bit 8 is 0, faults are ignored: there is no flush, no link write, and esr and ear do not change.
- R12: `rted` sets msr bit 8 and clears msr bit 9 in the next cycle. If a fault is taken in the same cycle, the exception wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Main reset, active high, synchronous |
| dbg_rst | input | 1 | Debug reset, active high, synchronous |
| instr_vld | input | 1 | Decode-stage instruction is valid |
| instr | input | 32 | Decode-stage instruction word |
| dec_pc | input | AW | Decode-stage PC |
| dec_dslot | input | 1 | Decode-stage instruction is in a branch delay slot |
| br_target | input | AW | Target of the branch owning the delay slot |
| ibus_err | input | 1 | Instruction bus slave error |
| ibus_tmo | input | 1 | Instruction bus arbiter timeout |
| ibus_periph | input | 1 | Fetch went to the peripheral bus |
| dbus_err | input | 1 | Data bus slave error |
| dbus_tmo | input | 1 | Data bus arbiter timeout |
| dbus_periph | input | 1 | Data access went to the peripheral bus |
| unaligned | input | 1 | Unaligned data access |
| data_addr | input | AW | Data access address |
| div_zero | input | 1 | Integer divide by zero |
| fp_err | input | FPN | FP faults: underflow, overflow, divide by zero, invalid, denormal |
| rted | input | 1 | Return-from-exception executes |
| flush | output | 1 | Flush the pipeline and squash the execute stage |
| redir_vld | output | 1 | Redirect fetch |
| redir_pc | output | AW | Redirect address |
| link_we | output | 1 | Write the link register |
| link_idx | output | 5 | Link register index (17) |
| link_data | output | AW | Return address to write |
| msr | output | 32 | Status register |
| esr | output | 32 | Exception-status register |
| ear | output | AW | Exception-address register |
| fsr | output | FPN | FP-status register |
| btr | output | AW | Branch-target register |

## Verification
The hardest situation to reach is a fault that arrives while an earlier exception is still in progress. It can only happen after a first exception has been taken and before any `rted`. The bench reaches it in that order: it takes an exception, then raises a second fault in the gap, and confirms that no flush follows and that esr and ear keep the first exception's values. The optional-unit cases need a second copy of the controller built without divider and FPU. Both copies see the same stimulus, so one divide, float or opcode-0x12/0x16 pattern shows the two outcomes side by side.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int CODE_W = 3;
  typedef enum logic [CODE_W-1:0] {
    C_NONE  = 3'd0,
    C_UNAL  = 3'd1,
    C_ILL   = 3'd2,
    C_IBUS  = 3'd3,
    C_DBUS  = 3'd4,
    C_DIVZ  = 3'd5,
    C_FPU   = 3'd6
  } cause_e;

  typedef enum logic [1:0] {
    EA_KEEP = 2'd0,
    EA_PC   = 2'd1,
    EA_DATA = 2'd2
  } ear_sel_e;

  localparam int MSR_EE  = 8;
  localparam int MSR_EIP = 9;
  localparam int ESR_DS  = 12;
  localparam int OPC_W   = 6;
endpackage

// File: rtl/exc_opcode_chk.sv
module exc_opcode_chk #(
  parameter int unsigned IW      = 32,
  parameter bit          HAS_DIV = 1'b1,
  parameter bit          HAS_FPU = 1'b1,
  parameter logic [5:0]  OPC_DIV = 6'h12,
  parameter logic [5:0]  OPC_FPU = 6'h16
) (
  input  logic          vld,
  input  logic [IW-1:0] instr,
  output logic          illegal
);
  import exc_pkg::*;
  localparam int OP_LSB = IW - OPC_W;

  logic [OPC_W-1:0] op;
  logic reserved, div_off, fpu_off;

  assign op       = instr[IW-1:OP_LSB];
  assign reserved = (op[5:4] == 2'b11);

  generate
    if (HAS_DIV) begin : g_div_on
      assign div_off = 1'b0;
    end else begin : g_div_off
      assign div_off = (op == OPC_DIV);
    end
    if (HAS_FPU) begin : g_fpu_on
      assign fpu_off = 1'b0;
    end else begin : g_fpu_off
      assign fpu_off = (op == OPC_FPU);
    end
  endgenerate

  assign illegal = vld & (reserved | div_off | fpu_off);
endmodule

// File: rtl/exc_cause_sel.sv
module exc_cause_sel #(
  parameter bit          HAS_DIV = 1'b1,
  parameter bit          HAS_FPU = 1'b1,
  parameter int unsigned FPN     = 5
) (
  input  logic           ibus_err,
  input  logic           ibus_tmo,
  input  logic           ibus_periph,
  input  logic           dbus_err,
  input  logic           dbus_tmo,
  input  logic           dbus_periph,
  input  logic           illegal,
  input  logic           unaligned,
  input  logic           div_zero,
  input  logic [FPN-1:0] fp_err,
  output logic           cause_vld,
  output exc_pkg::cause_e   code,
  output exc_pkg::ear_sel_e ear_sel
);
  import exc_pkg::*;

  logic ibus_f, dbus_f, div_f, fp_f;

  assign ibus_f = ibus_periph & (ibus_err | ibus_tmo);
  assign dbus_f = dbus_periph & (dbus_err | dbus_tmo);

  generate
    if (HAS_DIV) begin : g_div
      assign div_f = div_zero;
    end else begin : g_nodiv
      assign div_f = 1'b0;
    end
    if (HAS_FPU) begin : g_fp
      assign fp_f = |fp_err;
    end else begin : g_nofp
      assign fp_f = 1'b0;
    end
  endgenerate

  always_comb begin
    code    = C_NONE;
    ear_sel = EA_KEEP;
    if (ibus_f) begin
      code = C_IBUS;   ear_sel = EA_PC;
    end else if (illegal) begin
      code = C_ILL;
    end else if (dbus_f) begin
      code = C_DBUS;   ear_sel = EA_DATA;
    end else if (unaligned) begin
      code = C_UNAL;   ear_sel = EA_DATA;
    end else if (div_f) begin
      code = C_DIVZ;
    end else if (fp_f) begin
      code = C_FPU;
    end
  end

  assign cause_vld = (code != C_NONE);
endmodule

// File: rtl/exc_ctrl.sv
module exc_ctrl #(
  parameter int unsigned AW        = 32,
  parameter int unsigned FPN       = 5,
  parameter bit          HAS_DIV   = 1'b1,
  parameter bit          HAS_FPU   = 1'b1,
  parameter logic [31:0] RESET_MSR = 32'h0000_0100,
  parameter logic [31:0] VEC_RST   = 32'h0000_0000,
  parameter logic [31:0] VEC_EXC   = 32'h0000_0020,
  parameter logic [4:0]  LINK_REG  = 5'd17
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           dbg_rst,
  input  logic           instr_vld,
  input  logic [31:0]    instr,
  input  logic [AW-1:0]  dec_pc,
  input  logic           dec_dslot,
  input  logic [AW-1:0]  br_target,
  input  logic           ibus_err,
  input  logic           ibus_tmo,
  input  logic           ibus_periph,
  input  logic           dbus_err,
  input  logic           dbus_tmo,
  input  logic           dbus_periph,
  input  logic           unaligned,
  input  logic [AW-1:0]  data_addr,
  input  logic           div_zero,
  input  logic [FPN-1:0] fp_err,
  input  logic           rted,
  output logic           flush,
  output logic           redir_vld,
  output logic [AW-1:0]  redir_pc,
  output logic           link_we,
  output logic [4:0]     link_idx,
  output logic [AW-1:0]  link_data,
  output logic [31:0]    msr,
  output logic [31:0]    esr,
  output logic [AW-1:0]  ear,
  output logic [FPN-1:0] fsr,
  output logic [AW-1:0]  btr
);
  import exc_pkg::*;

  logic      rst_any, illegal, cause_vld, take;
  cause_e    code;
  ear_sel_e  ear_sel;

  assign rst_any = rst | dbg_rst;

  exc_opcode_chk #(.IW(32), .HAS_DIV(HAS_DIV), .HAS_FPU(HAS_FPU)) u_opc (
    .vld(instr_vld), .instr(instr), .illegal(illegal)
  );

  exc_cause_sel #(.HAS_DIV(HAS_DIV), .HAS_FPU(HAS_FPU), .FPN(FPN)) u_sel (
    .ibus_err(ibus_err), .ibus_tmo(ibus_tmo), .ibus_periph(ibus_periph),
    .dbus_err(dbus_err), .dbus_tmo(dbus_tmo), .dbus_periph(dbus_periph),
    .illegal(illegal), .unaligned(unaligned), .div_zero(div_zero),
    .fp_err(fp_err), .cause_vld(cause_vld), .code(code), .ear_sel(ear_sel)
  );

  assign take     = cause_vld & msr[MSR_EE] & ~msr[MSR_EIP];
  assign link_idx = LINK_REG;

  always_ff @(posedge clk) begin
    if (rst_any) begin
      flush     <= 1'b1;
      redir_vld <= 1'b1;
      redir_pc  <= VEC_RST[AW-1:0];
      link_we   <= 1'b0;
      link_data <= '0;
      msr       <= RESET_MSR;
      esr       <= '0;
      ear       <= '0;
      fsr       <= '0;
      btr       <= '0;
    end else begin
      flush     <= take;
      redir_vld <= take;
      link_we   <= take;
      if (take) begin
        redir_pc         <= VEC_EXC[AW-1:0];
        link_data        <= dec_pc;
        msr[MSR_EIP]     <= 1'b1;
        msr[MSR_EE]      <= 1'b0;
        esr              <= '0;
        esr[CODE_W-1:0]  <= code;
        esr[ESR_DS]      <= dec_dslot;
        if (dec_dslot) btr <= br_target;
        case (ear_sel)
          EA_PC:   ear <= dec_pc;
          EA_DATA: ear <= data_addr;
          default: ;
        endcase
        if (code == C_FPU) fsr <= fsr | fp_err;
      end else if (rted) begin
        msr[MSR_EE]  <= 1'b1;
        msr[MSR_EIP] <= 1'b0;
      end
    end
  end

  // R2: a taken fault leads to the exception vector
  a_r2_vector: assert property (@(posedge clk) disable iff (rst_any)
    take |=> (flush && redir_vld && redir_pc == VEC_EXC[AW-1:0]));

  // R3: the link write comes only together with a flush
  a_r3_link_flush: assert property (@(posedge clk) disable iff (rst_any)
    link_we |-> (flush && link_idx == LINK_REG));

  // R11: no new exception while one is in progress or exceptions are disabled
  a_r11_masked: assert property (@(posedge clk) disable iff (rst_any)
    (msr[MSR_EIP] || !msr[MSR_EE]) |=> (!link_we && $stable(esr)));

  // R12: return re-enables exceptions when nothing is taken
  a_r12_rted: assert property (@(posedge clk) disable iff (rst_any)
    (rted && !take) |=> (msr[MSR_EE] && !msr[MSR_EIP]));

  // R10: FP status bits never clear outside reset
  a_r10_sticky: assert property (@(posedge clk) disable iff (rst_any)
    1'b1 |=> ((fsr & $past(fsr)) == $past(fsr)));
endmodule

// File: tb/tb_exc_ctrl.sv
module tb_exc_ctrl;
  localparam int CLK_P = 10;
  localparam int AW = 32;
  localparam int FPN = 5;

  logic clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic rst, dbg_rst, instr_vld, dec_dslot, ibus_err, ibus_tmo, ibus_periph;
  logic dbus_err, dbus_tmo, dbus_periph, unaligned, div_zero, rted;
  logic [31:0] instr, dec_pc, br_target, data_addr;
  logic [FPN-1:0] fp_err;

  logic flush, redir_vld, link_we;
  logic [4:0] link_idx;
  logic [31:0] redir_pc, link_data, msr, esr, ear, btr;
  logic [FPN-1:0] fsr;

  logic n_flush, n_redir_vld, n_link_we;
  logic [4:0] n_link_idx;
  logic [31:0] n_redir_pc, n_link_data, n_msr, n_esr, n_ear, n_btr;
  logic [FPN-1:0] n_fsr;

  exc_ctrl dut (
    .clk, .rst, .dbg_rst, .instr_vld, .instr, .dec_pc, .dec_dslot, .br_target,
    .ibus_err, .ibus_tmo, .ibus_periph, .dbus_err, .dbus_tmo, .dbus_periph,
    .unaligned, .data_addr, .div_zero, .fp_err, .rted,
    .flush, .redir_vld, .redir_pc, .link_we, .link_idx, .link_data,
    .msr, .esr, .ear, .fsr, .btr
  );

  exc_ctrl #(.HAS_DIV(1'b0), .HAS_FPU(1'b0)) dut_nopt (
    .clk, .rst, .dbg_rst, .instr_vld, .instr, .dec_pc, .dec_dslot, .br_target,
    .ibus_err, .ibus_tmo, .ibus_periph, .dbus_err, .dbus_tmo, .dbus_periph,
    .unaligned, .data_addr, .div_zero, .fp_err, .rted,
    .flush(n_flush), .redir_vld(n_redir_vld), .redir_pc(n_redir_pc),
    .link_we(n_link_we), .link_idx(n_link_idx), .link_data(n_link_data),
    .msr(n_msr), .esr(n_esr), .ear(n_ear), .fsr(n_fsr), .btr(n_btr)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    instr_vld = 0; instr = 32'h0; dec_dslot = 0;
    ibus_err = 0; ibus_tmo = 0; ibus_periph = 0;
    dbus_err = 0; dbus_tmo = 0; dbus_periph = 0;
    unaligned = 0; div_zero = 0; fp_err = '0; rted = 0;
  endtask

  // one strobe cycle: inputs set by caller before, checked after this returns
  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_rted();
    idle(); rted = 1; step(); rted = 0;
    chk("R12 rted enable", {30'b0, msr[9], msr[8]}, 32'h1);
    step();
  endtask

  task automatic t_reset(input bit use_dbg);
    rst = !use_dbg; dbg_rst = use_dbg; idle();
    step(); step();
    chk("R1 flush", {31'b0, flush}, 32'h1);
    chk("R1 redir", {31'b0, redir_vld}, 32'h1);
    chk("R1 pc", redir_pc, 32'h0);
    chk("R1 msr", msr, 32'h100);
    chk("R1 esr", esr, 32'h0);
    chk("R1 ear", ear, 32'h0);
    chk("R1 fsr", {27'b0, fsr}, 32'h0);
    chk("R1 btr", btr, 32'h0);
    chk("R1 link_we", {31'b0, link_we}, 32'h0);
    rst = 0; dbg_rst = 0;
    step();
    chk("R1 release", {31'b0, flush}, 32'h0);
  endtask

  task automatic t_ibus();
    idle(); dec_pc = 32'h0000_1000; ibus_err = 1; ibus_periph = 0;
    step(); idle();
    chk("R6 local ibus ignored", {31'b0, flush}, 32'h0);
    ibus_tmo = 1; ibus_periph = 1; dec_pc = 32'h0000_2004;
    step(); idle();
    chk("R2 flush", {31'b0, flush}, 32'h1);
    chk("R2 pc", redir_pc, 32'h20);
    chk("R3 link_we", {31'b0, link_we}, 32'h1);
    chk("R3 link_idx", {27'b0, link_idx}, 32'd17);
    chk("R3 link_data", link_data, 32'h0000_2004);
    chk("R7 code ibus", {29'b0, esr[2:0]}, 32'd3);
    chk("R8 ear pc", ear, 32'h0000_2004);
    chk("R11 msr", {30'b0, msr[9], msr[8]}, 32'h2);
    step();
    chk("R2 one cycle", {30'b0, flush, redir_vld}, 32'h0);
    do_rted();
  endtask

  task automatic t_mask();
    idle(); dbus_err = 1; dbus_periph = 1; data_addr = 32'hA000_0004; dec_pc = 32'h300;
    step(); idle();
    chk("R6 dbus taken", {31'b0, flush}, 32'h1);
    chk("R8 ear data", ear, 32'hA000_0004);
    unaligned = 1; data_addr = 32'hB000_0001;
    step(); idle();
    chk("R11 masked flush", {31'b0, flush}, 32'h0);
    chk("R11 masked esr", {29'b0, esr[2:0]}, 32'd4);
    chk("R11 masked ear", ear, 32'hA000_0004);
    // exception wins over rted in same cycle: still masked, so rted alone now
    do_rted();
    dbus_tmo = 1; dbus_periph = 0; unaligned = 0;
    step(); idle();
    chk("R6 local dbus ignored", {31'b0, flush}, 32'h0);
  endtask

  task automatic t_prio();
    idle(); ibus_err = 1; ibus_periph = 1; instr_vld = 1; instr = 32'hFC00_0000;
    dbus_err = 1; dbus_periph = 1; dec_pc = 32'h440; data_addr = 32'h55;
    step(); idle();
    chk("R7 ibus first", {29'b0, esr[2:0]}, 32'd3);
    do_rted();
    instr_vld = 1; instr = 32'hC3FF_FFFF; dbus_tmo = 1; dbus_periph = 1;
    data_addr = 32'h66; dec_pc = 32'h500;
    step(); idle();
    chk("R7 illegal over dbus", {29'b0, esr[2:0]}, 32'd2);
    chk("R8 ear kept on illegal", ear, 32'h440);
    do_rted();
    unaligned = 1; div_zero = 1; fp_err = 5'h01; data_addr = 32'h77;
    step(); idle();
    chk("R7 unaligned over div", {29'b0, esr[2:0]}, 32'd1);
    chk("R8 ear unaligned", ear, 32'h77);
    do_rted();
    div_zero = 1; fp_err = 5'h01;
    step(); idle();
    chk("R7 div over fp", {29'b0, esr[2:0]}, 32'd5);
    chk("R9 nodiv ignored", {31'b0, n_flush}, 32'h0);
    do_rted();
  endtask

  task automatic t_opcode();
    idle(); instr_vld = 1; instr = {6'h2F, 26'h3FF_FFFF};
    step(); idle();
    chk("R5 0x2F legal", {31'b0, flush}, 32'h0);
    instr_vld = 0; instr = {6'h30, 26'h0};
    step(); idle();
    chk("R5 invalid slot ignored", {31'b0, flush}, 32'h0);
    instr_vld = 1; instr = {6'h12, 26'h1234};
    step(); idle();
    chk("R5 div opcode legal with div", {31'b0, flush}, 32'h0);
    chk("R5 div opcode illegal without div", {29'b0, n_esr[2:0]}, 32'd2);
    do_rted();
    instr_vld = 1; instr = {6'h16, 26'h0};
    step(); idle();
    chk("R5 fpu opcode legal with fpu", {31'b0, flush}, 32'h0);
    chk("R5 fpu opcode illegal without fpu", {31'b0, n_flush}, 32'h1);
    do_rted();
  endtask

  task automatic t_fp_dslot();
    idle(); fp_err = 5'b00100; dec_dslot = 1; br_target = 32'hCAFE_0000; dec_pc = 32'h600;
    step(); idle();
    chk("R10 fsr", {27'b0, fsr}, 32'h4);
    chk("R4 ds bit", {31'b0, esr[12]}, 32'h1);
    chk("R4 btr", btr, 32'hCAFE_0000);
    chk("R7 fp code", {29'b0, esr[2:0]}, 32'd6);
    chk("R9 nofpu fsr", {27'b0, n_fsr}, 32'h0);
    chk("R9 nofpu no flush", {31'b0, n_flush}, 32'h0);
    do_rted();
    fp_err = 5'b10001; br_target = 32'h1111_1111;
    step(); idle();
    chk("R10 sticky", {27'b0, fsr}, 32'h15);
    chk("R4 ds clear", {31'b0, esr[12]}, 32'h0);
    chk("R4 btr kept", btr, 32'hCAFE_0000);
    step();
    // R12: rted and fault in same cycle - exception wins (state: EIP set, so rted first)
    do_rted();
    unaligned = 1; rted = 1;
    step(); idle();
    chk("R12 exception wins", {30'b0, msr[9], msr[8]}, 32'h2);
    // R1 via debug reset while in progress
    t_reset(1'b1);
  endtask

  initial begin
    rst = 1; dbg_rst = 0; idle();
    dec_pc = 0; br_target = 0; data_addr = 0;
    t_reset(1'b0);
    t_ibus();
    t_mask();
    t_prio();
    t_opcode();
    t_fp_dslot();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule